// File: doc/BRIEF.md
# Aging Priority Memory Arbiter

This block picks which of several bus masters gets the next transaction on one shared SDRAM controller. Each master presents a pending request together with its transfer direction, the bank it targets and its burst length in beats. The arbiter holds one grant at a time and releases it only when the controller reports that the burst has finished. The choice for the following transfer is made on that same clock edge, so consecutive bursts follow each other with no idle arbitration cycle.

A winner is chosen by comparing a small key per master. The most significant part of the key is promotion by waiting time. Every master has a wait limit that software programs through a simple write port. A master whose wait counter has passed that limit beats all others. Next comes a preference for the transfer direction of the previous grant, which keeps reads together and writes together. After that comes a preference for a bank other than the one just used, so that bank accesses can interleave. The last tie-breaker is a fixed rank, with index 0 highest. The intended order for a six-master system is I/O DMA, stream input, video processing, flash interface, video decoder and then graphics.

The winner's index, direction, bank and burst length are registered and held for the controller, and a one-cycle pulse marks each new grant.

Top module: `mem_age_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy` is 0, `grant_pulse` is 0 and `grant` is all zeros. Every wait limit resets to all ones.
- R2: With no previous grant since reset, simultaneous eligible requests from idle are granted to the lowest index on the clock edge after they are first seen. `grant_pulse` is high for exactly that one cycle and `grant` is the one-hot of `grant_idx`.
- R3: While `busy` is high and `burst_done` is low, `grant_idx`, `grant` and the grant fields stay unchanged and no new pulse is issued.
- R4: When `burst_done` is high during a grant and another eligible request is pending, the new grant takes effect on that same edge. `busy` stays high with no idle cycle. If nothing is pending, `busy` falls on that edge.
- R5: Among eligible requests, one whose direction (`req_write`, 1 = write) equals the direction of the last grant beats one of the other direction, whatever their fixed rank.
- R6: Among requests that tie on direction, one whose bank (`req_bank` field m at bits [m*BANK_W +: BANK_W]) differs from the last granted bank beats one targeting the same bank.
- R7: The direction preference outranks the bank preference.
- R8: A master whose wait counter exceeds its programmed limit beats every master that has not exceeded its own limit. The wait counter counts clock edges at which the master was eligible but not granted. The limit for master m is written when `cfg_we` is high, with `cfg_addr` = m and `cfg_wdata` = limit.
- R9: A master's wait counter clears to zero on the edge at which it is granted.
- R10: Only burst lengths of 1, 2, 3, 5, 6, 7 and 8 beats (`req_blen` field m at bits [m*BLEN_W +: BLEN_W], value = beat count) are eligible. Requests with any other length are never granted.
- R11: `grant_write`, `grant_bank` and `grant_blen` carry the winner's request fields exactly.
- R12: A wait counter saturates at its maximum value and does not wrap. A limit of all ones therefore never promotes.
- R13: The master currently holding the grant is not a candidate in the decision made at its own `burst_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_MASTERS | Pending request per master |
| req_write | input | N_MASTERS | Direction per master, 1 = write |
| req_bank | input | N_MASTERS*BANK_W | Target bank per master |
| req_blen | input | N_MASTERS*BLEN_W | Burst length in beats per master |
| burst_done | input | 1 | Controller reports the granted burst complete |
| cfg_we | input | 1 | Wait-limit write strobe |
| cfg_addr | input | IDX_W | Master whose limit is written |
| cfg_wdata | input | AGE_W | New wait limit |
| grant | output | N_MASTERS | One-hot grant, held during the burst |
| grant_idx | output | IDX_W | Index of the granted master |
| grant_pulse | output | 1 | High for one cycle per new grant |
| grant_write | output | 1 | Direction of the granted transfer |
| grant_bank | output | BANK_W | Bank of the granted transfer |
| grant_blen | output | BLEN_W | Burst length of the granted transfer |
| busy | output | 1 | A grant is outstanding |

## Verification
Two functions meet on one clock edge: the completion of a burst and the decision that starts the next one. The bench raises `burst_done` while several requests with mixed directions, banks and wait ages are pending. It then checks, in the cycle after that edge, that the new index has a fresh pulse and that `busy` never dropped. Wait-counter clearing and promotion also coincide with grants. To judge these, the bench re-requests a freshly served master straight away and confirms that a higher-ranked rival wins. This shows that the earlier promotion did not survive the grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef struct packed {
    logic aged;
    logic same_dir;
    logic other_bank;
  } prio_key_t;

  function automatic logic burst_ok(input int unsigned beats);
    return (beats >= 1) && (beats <= 8) && (beats != 4);
  endfunction

endpackage

// File: rtl/arb_age_bank.sv
module arb_age_bank #(
  parameter int N_MASTERS = 6,
  parameter int AGE_W     = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_addr,
  input  logic [AGE_W-1:0]     cfg_wdata,
  input  logic [N_MASTERS-1:0] wait_mask,
  input  logic [N_MASTERS-1:0] clear_mask,
  output logic [N_MASTERS-1:0] aged
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_master
    logic [AGE_W-1:0] limit_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        limit_q <= AGE_MAX;
      end else if (cfg_we && cfg_addr == IDX_W'(m)) begin
        limit_q <= cfg_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        age_q <= '0;
      end else if (clear_mask[m]) begin
        age_q <= '0;
      end else if (wait_mask[m] && age_q != AGE_MAX) begin
        age_q <= age_q + 1'b1;
      end
    end

    assign aged[m] = age_q > limit_q;
  end

endmodule

// File: rtl/arb_key_gen.sv
module arb_key_gen
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 6,
  parameter int BANK_W    = 2
) (
  input  logic [N_MASTERS-1:0]        aged,
  input  logic [N_MASTERS-1:0]        req_write,
  input  logic [N_MASTERS*BANK_W-1:0] req_bank,
  input  logic                        have_last,
  input  logic                        last_write,
  input  logic [BANK_W-1:0]           last_bank,
  output prio_key_t                   keys [N_MASTERS]
);

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_key
    always_comb begin
      keys[m].aged       = aged[m];
      keys[m].same_dir   = have_last && (req_write[m] == last_write);
      keys[m].other_bank = have_last && (req_bank[m*BANK_W +: BANK_W] != last_bank);
    end
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 6,
  parameter int IDX_W     = 3
) (
  input  logic [N_MASTERS-1:0] eligible,
  input  prio_key_t            keys [N_MASTERS],
  output logic                 found,
  output logic [IDX_W-1:0]     win_idx
);

  prio_key_t best;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int m = N_MASTERS - 1; m >= 0; m--) begin
      if (eligible[m] && (!found || keys[m] >= best)) begin
        found   = 1'b1;
        win_idx = IDX_W'(m);
        best    = keys[m];
      end
    end
  end

endmodule

// File: rtl/mem_age_arbiter.sv
module mem_age_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 6,
  parameter int BANK_W    = 2,
  parameter int BLEN_W    = 4,
  parameter int AGE_W     = 8,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_MASTERS-1:0]        req_valid,
  input  logic [N_MASTERS-1:0]        req_write,
  input  logic [N_MASTERS*BANK_W-1:0] req_bank,
  input  logic [N_MASTERS*BLEN_W-1:0] req_blen,
  input  logic                        burst_done,
  input  logic                        cfg_we,
  input  logic [IDX_W-1:0]            cfg_addr,
  input  logic [AGE_W-1:0]            cfg_wdata,
  output logic [N_MASTERS-1:0]        grant,
  output logic [IDX_W-1:0]            grant_idx,
  output logic                        grant_pulse,
  output logic                        grant_write,
  output logic [BANK_W-1:0]           grant_bank,
  output logic [BLEN_W-1:0]           grant_blen,
  output logic                        busy
);

  logic [N_MASTERS-1:0] eligible;
  logic [N_MASTERS-1:0] aged;
  logic [N_MASTERS-1:0] win_mask;
  logic [N_MASTERS-1:0] wait_mask;
  logic [N_MASTERS-1:0] clear_mask;
  prio_key_t            keys [N_MASTERS];
  logic                 found;
  logic [IDX_W-1:0]     win_idx;
  logic                 take;
  logic                 have_last_q;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_elig
    assign eligible[m] = req_valid[m]
                       && burst_ok(int'(req_blen[m*BLEN_W +: BLEN_W]))
                       && !(busy && grant_idx == IDX_W'(m));
    assign win_mask[m] = found && (win_idx == IDX_W'(m));
  end

  assign take       = found && (!busy || burst_done);
  assign clear_mask = take ? win_mask : '0;
  assign wait_mask  = eligible & ~clear_mask;

  arb_age_bank #(
    .N_MASTERS (N_MASTERS),
    .AGE_W     (AGE_W),
    .IDX_W     (IDX_W)
  ) u_age (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .wait_mask  (wait_mask),
    .clear_mask (clear_mask),
    .aged       (aged)
  );

  arb_key_gen #(
    .N_MASTERS (N_MASTERS),
    .BANK_W    (BANK_W)
  ) u_key (
    .aged       (aged),
    .req_write  (req_write),
    .req_bank   (req_bank),
    .have_last  (have_last_q),
    .last_write (grant_write),
    .last_bank  (grant_bank),
    .keys       (keys)
  );

  arb_pick #(
    .N_MASTERS (N_MASTERS),
    .IDX_W     (IDX_W)
  ) u_pick (
    .eligible (eligible),
    .keys     (keys),
    .found    (found),
    .win_idx  (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      grant_pulse <= 1'b0;
      grant       <= '0;
      grant_idx   <= '0;
      grant_write <= 1'b0;
      grant_bank  <= '0;
      grant_blen  <= '0;
      have_last_q <= 1'b0;
    end else begin
      grant_pulse <= take;
      if (take) begin
        busy        <= 1'b1;
        grant       <= win_mask;
        grant_idx   <= win_idx;
        grant_write <= req_write[win_idx];
        grant_bank  <= req_bank[win_idx*BANK_W +: BANK_W];
        grant_blen  <= req_blen[win_idx*BLEN_W +: BLEN_W];
        have_last_q <= 1'b1;
      end else if (burst_done && busy) begin
        busy  <= 1'b0;
        grant <= '0;
      end
    end
  end

endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 6,
  parameter int BLEN_W    = 4,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_MASTERS-1:0] req_valid,
  input logic                 burst_done,
  input logic [N_MASTERS-1:0] grant,
  input logic [IDX_W-1:0]     grant_idx,
  input logic                 grant_pulse,
  input logic [BLEN_W-1:0]    grant_blen,
  input logic                 busy
);

  // R2: grant vector is one-hot while busy, empty otherwise
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(grant) == 1 && grant[grant_idx]));
  a_r2_idle_empty: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (grant == '0 && !grant_pulse));

  // R3: grant held until the burst completes
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !burst_done) |=> (busy && $stable(grant_idx) && !grant_pulse));

  // R4: a new grant only appears after idle or a completion
  a_r4_new_grant_cause: assert property (@(posedge clk) disable iff (rst)
    grant_pulse |-> $past(!busy || burst_done));

  // R10: granted burst length is a legal one
  a_r10_legal_len: assert property (@(posedge clk) disable iff (rst)
    grant_pulse |-> burst_ok(int'(grant_blen)));

  // R11: winner had a pending request
  a_r11_was_requesting: assert property (@(posedge clk) disable iff (rst)
    grant_pulse |-> ((($past(req_valid) >> grant_idx) & 1) == 1));

  // R13: the holder never wins its own completion decision
  a_r13_holder_excluded: assert property (@(posedge clk) disable iff (rst)
    (grant_pulse && $past(busy)) |-> (grant_idx != $past(grant_idx)));

endmodule

bind mem_age_arbiter arb_checker #(
  .N_MASTERS (N_MASTERS),
  .BLEN_W    (BLEN_W),
  .IDX_W     (IDX_W)
) u_arb_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .burst_done  (burst_done),
  .grant       (grant),
  .grant_idx   (grant_idx),
  .grant_pulse (grant_pulse),
  .grant_blen  (grant_blen),
  .busy        (busy)
);

// File: tb/mem_age_arbiter_test.sv
module mem_age_arbiter_test;

  localparam int N  = 6;
  localparam int BW = 2;
  localparam int LW = 4;
  localparam int AW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_valid = '0;
  logic [N-1:0]  req_write = '0;
  logic [N*BW-1:0] req_bank = '0;
  logic [N*LW-1:0] req_blen = '0;
  logic          burst_done = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [N-1:0]  grant;
  logic [IW-1:0] grant_idx;
  logic          grant_pulse;
  logic          grant_write;
  logic [BW-1:0] grant_bank;
  logic [LW-1:0] grant_blen;
  logic          busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mem_age_arbiter #(.N_MASTERS(N), .BANK_W(BW), .BLEN_W(LW), .AGE_W(AW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_blen(req_blen), .burst_done(burst_done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .grant(grant), .grant_idx(grant_idx), .grant_pulse(grant_pulse),
    .grant_write(grant_write), .grant_bank(grant_bank), .grant_blen(grant_blen),
    .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_req(input int m, input bit v, input bit w, input int bank, input int blen);
    req_valid[m] = v;
    req_write[m] = w;
    req_bank[m*BW +: BW] = BW'(bank);
    req_blen[m*LW +: LW] = LW'(blen);
  endtask

  task automatic expect_grant(input string tag, input int idx);
    check(grant_pulse === 1'b1, {tag, " pulse"}, int'(grant_pulse), 1);
    check(int'(grant_idx) == idx, {tag, " index"}, int'(grant_idx), idx);
    check(busy === 1'b1, {tag, " busy"}, int'(busy), 1);
  endtask

  // completion with the next decision on the same edge; winner drops its request
  task automatic done_expect(input string tag, input int idx);
    @(negedge clk);
    burst_done = 1'b1;
    tick();
    expect_grant(tag, idx);
    @(negedge clk);
    burst_done = 1'b0;
    req_valid[idx] = 1'b0;
  endtask

  task automatic cfg_limit(input int m, input int lim);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = IW'(m);
    cfg_wdata = AW'(lim);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = '0;
    req_write = '0;
    req_bank = '0;
    req_blen = '0;
    burst_done = 1'b0;
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && grant_pulse === 1'b0 && grant === '0, "R1 in reset", int'(busy), 0);
    rst = 1'b0;
    tick();
    check(busy === 1'b0 && grant_pulse === 1'b0 && grant === '0, "R1 after reset", int'(grant), 0);
  endtask

  // R2 R3 R4 R11: base rank, hold, back-to-back grants
  task automatic t_base_rank();
    do_reset();
    @(negedge clk);
    set_req(3, 1, 0, 0, 2);
    set_req(1, 1, 0, 0, 5);
    set_req(4, 1, 0, 0, 3);
    tick();
    expect_grant("R2 lowest index", 1);
    check(grant === 6'b000010, "R2 one-hot", int'(grant), 2);
    check(grant_blen === 4'd5 && grant_write === 1'b0, "R11 fields", int'(grant_blen), 5);
    @(negedge clk);
    req_valid[1] = 1'b0;
    repeat (4) tick();
    check(grant_pulse === 1'b0 && int'(grant_idx) == 1 && busy === 1'b1, "R3 held", int'(grant_idx), 1);
    done_expect("R4 back-to-back", 3);
    check(grant_blen === 4'd2, "R11 blen", int'(grant_blen), 2);
    tick();
    check(grant_pulse === 1'b0, "R2 single pulse", int'(grant_pulse), 0);
    done_expect("R4 back-to-back second", 4);
    @(negedge clk);
    burst_done = 1'b1;
    tick();
    check(busy === 1'b0 && grant === '0, "R4 release when empty", int'(busy), 0);
    @(negedge clk);
    burst_done = 1'b0;
  endtask

  // R5 R7: direction grouping, above bank preference
  task automatic t_direction();
    do_reset();
    @(negedge clk);
    set_req(4, 1, 0, 1, 1);
    tick();
    expect_grant("R5 first read", 4);
    @(negedge clk);
    req_valid[4] = 1'b0;
    set_req(1, 1, 1, 2, 8);
    set_req(3, 1, 0, 1, 6);
    done_expect("R7 same dir over other bank", 3);
    done_expect("R5 write alone", 1);
    check(grant_write === 1'b1 && grant_bank === 2'd2 && grant_blen === 4'd8, "R11 write fields", int'(grant_blen), 8);
    set_req(0, 1, 0, 3, 1);
    set_req(2, 1, 1, 2, 7);
    done_expect("R5 write after write", 2);
    check(grant_blen === 4'd7, "R11 blen seven", int'(grant_blen), 7);
    done_expect("R5 remaining read", 0);
  endtask

  // R6: other bank preferred when direction ties
  task automatic t_bank();
    do_reset();
    @(negedge clk);
    set_req(2, 1, 0, 0, 3);
    tick();
    expect_grant("R6 setup", 2);
    @(negedge clk);
    req_valid[2] = 1'b0;
    set_req(0, 1, 0, 0, 3);
    set_req(4, 1, 0, 3, 3);
    done_expect("R6 other bank", 4);
    check(grant_bank === 2'd3, "R11 bank", int'(grant_bank), 3);
    done_expect("R6 then same bank", 0);
  endtask

  // R8 R9: promotion by wait limit, cleared on grant
  task automatic t_aging();
    do_reset();
    cfg_limit(5, 3);
    @(negedge clk);
    set_req(2, 1, 1, 1, 2);
    tick();
    expect_grant("R8 setup", 2);
    @(negedge clk);
    req_valid[2] = 1'b0;
    set_req(5, 1, 0, 1, 2);
    set_req(0, 1, 1, 2, 2);
    repeat (8) @(negedge clk);
    done_expect("R8 aged master wins", 5);
    done_expect("R9 rival next", 0);
    set_req(3, 1, 1, 2, 2);
    set_req(5, 1, 1, 2, 2);
    done_expect("R9 age cleared, rank decides", 3);
    done_expect("R9 remaining", 5);
  endtask

  // R12: saturation promotes at limit max-1, never at max
  task automatic t_saturate();
    do_reset();
    cfg_limit(5, 254);
    @(negedge clk);
    set_req(1, 1, 1, 0, 1);
    tick();
    expect_grant("R12 setup", 1);
    @(negedge clk);
    req_valid[1] = 1'b0;
    set_req(5, 1, 0, 0, 1);
    set_req(2, 1, 1, 0, 1);
    repeat (300) @(negedge clk);
    done_expect("R12 saturated counter promotes", 5);
    done_expect("R12 rest", 2);

    do_reset();
    @(negedge clk);
    set_req(1, 1, 1, 0, 1);
    tick();
    expect_grant("R12 setup max", 1);
    @(negedge clk);
    req_valid[1] = 1'b0;
    set_req(5, 1, 0, 0, 1);
    set_req(2, 1, 1, 0, 1);
    repeat (300) @(negedge clk);
    done_expect("R12 max limit never promotes", 2);
    done_expect("R12 rest max", 5);
  endtask

  // R10: every length value from idle
  task automatic t_lengths();
    do_reset();
    for (int v = 0; v < 16; v++) begin
      bit legal;
      legal = (v >= 1 && v <= 8 && v != 4);
      @(negedge clk);
      set_req(0, 1, 0, 0, v);
      tick();
      if (legal) begin
        check(grant_pulse === 1'b1 && int'(grant_blen) == v, "R10 legal length granted", int'(grant_blen), v);
      end else begin
        tick();
        check(busy === 1'b0 && grant_pulse === 1'b0, "R10 illegal length ignored", int'(busy), 0);
      end
      @(negedge clk);
      req_valid[0] = 1'b0;
      burst_done = 1'b1;
      @(negedge clk);
      burst_done = 1'b0;
    end
  endtask

  // R13: holder keeps requesting, yet a lower rank wins at its completion
  task automatic t_holder();
    do_reset();
    @(negedge clk);
    set_req(0, 1, 0, 0, 2);
    tick();
    expect_grant("R13 setup", 0);
    @(negedge clk);
    set_req(1, 1, 0, 0, 2);
    done_expect("R13 holder excluded", 1);
    done_expect("R13 holder again later", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_base_rank();
    t_direction();
    t_bank();
    t_aging();
    t_saturate();
    t_lengths();
    t_holder();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule